// File: doc/BRIEF.md
# ADC Control/Status Register and Conversion Sequencer

This block holds the 8-bit control/status register of an analog-to-digital converter. It also contains the sequencer that this register drives. Software writes the register to choose a channel, pick single or scan mode, enable the end-of-conversion interrupt and start work. The sequencer then gives the external converter a one-cycle start strobe and a channel number. It waits for the converter's done pulse and stores the returned result word in a result register for that channel.

The end flag is tightly guarded. Software can clear it only by writing 0 to it after a read that saw it at 1. A transfer controller, triggered by the interrupt, clears it as a side effect of reading a result register. In scan mode the flag marks the end of a whole pass over the selected channels, not the end of each conversion. The interrupt request is the end flag gated by the enable bit. Entry to a low-power state returns the register to zero, in the same way as reset.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, and in any cycle where `lp_i` is high, every bit of the control/status register is 0. `irq_o` and `conv_start_o` are then low.
- R2: The register is read and written at address 0. Bit 7 is the end flag, bit 6 the interrupt enable, bit 5 start, bit 4 scan mode, and bits 3:0 the channel. The result of channel c is read at address 16+c, right-aligned in `reg_rdata_o`.
- R3: The end flag is cleared by a register write with bit 7 = 0 only if a CPU read of the register since the last write returned the flag as 1. A write of 1 to bit 7 never sets or clears the flag, and it also cancels the earlier read.
- R4: A read of a result register with `xfer_i` high clears the end flag. A CPU read of a result register (with `xfer_i` low) leaves it unchanged.
- R5: In single mode, start gives one strobe for the selected channel. The done pulse then sets the end flag and clears the start bit.
- R6: In scan mode, conversions run from the lowest channel of the selected group of four up to the selected channel, then wrap back to the group base. The flag sets only when the selected channel finishes, and the start bit stays 1.
- R7: Each done pulse stores `conv_result_i` into the result register of the channel being converted.
- R8: `irq_o` is high exactly while the end flag and the interrupt enable are both 1.
- R9: When a conversion end and a flag clear fall in the same cycle, the flag ends up set.
- R10: Writing start = 0 while a scan is running stops the sequence. No further strobes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_i | input | 1 | Low-power entry; clears the register and stops the sequencer |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| xfer_i | input | 1 | Marks the current read as coming from the transfer controller |
| reg_addr_i | input | 5 | Register address (0 = control/status, 16+c = result c) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Conversion-end interrupt request |
| conv_start_o | output | 1 | One-cycle start strobe to the converter |
| conv_ch_o | output | 4 | Channel for the converter |
| conv_done_i | input | 1 | Conversion done pulse |
| conv_result_i | input | 10 | Conversion result, valid with done |

## Verification
The bench runs single mode on all sixteen channels and scan mode on every selected channel with two full passes. This catches a wrong group base, a missing wrap, or a flag that rises after each scan step instead of at the end of the pass. The flag-clear tests write zero without a prior read, write one after a read, and issue a transfer read in the same cycle as a done pulse. A design that clears without arming would lose the flag too early, and one that lets the clear win would lose a conversion event. A stop written during a scan must silence the strobe, and low-power entry must blank the register.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CSR_FLAG  = 7;
  localparam int CSR_IE    = 6;
  localparam int CSR_START = 5;
  localparam int CSR_SCAN  = 4;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_csr.sv
module adc_csr #(
  parameter int CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lp_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [7:0]      wdata_i,
  input  logic            xfer_clr_i,
  input  logic            end_set_i,
  input  logic            single_done_i,
  output logic [7:0]      csr_o,
  output logic            start_load_o,
  output logic            flag_o,
  output logic            ie_o,
  output logic            start_o,
  output logic            scan_o,
  output logic [CH_W-1:0] ch_o
);
  import adc_seq_pkg::*;

  logic            flag_q, armed_q, ie_q, start_q, scan_q;
  logic [CH_W-1:0] ch_q;
  logic            sw_clr;

  assign sw_clr = wr_i && !wdata_i[CSR_FLAG] && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      ie_q    <= 1'b0;
      start_q <= 1'b0;
      scan_q  <= 1'b0;
      ch_q    <= '0;
    end else if (lp_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      ie_q    <= 1'b0;
      start_q <= 1'b0;
      scan_q  <= 1'b0;
      ch_q    <= '0;
    end else begin
      // set has priority over any clear
      if (end_set_i)                 flag_q <= 1'b1;
      else if (sw_clr || xfer_clr_i) flag_q <= 1'b0;

      if (wr_i || xfer_clr_i)  armed_q <= 1'b0;
      else if (rd_i && flag_q) armed_q <= 1'b1;

      if (wr_i) begin
        ie_q    <= wdata_i[CSR_IE];
        start_q <= wdata_i[CSR_START];
        scan_q  <= wdata_i[CSR_SCAN];
        ch_q    <= wdata_i[CH_W-1:0];
      end else if (single_done_i) begin
        start_q <= 1'b0;
      end
    end
  end

  assign start_load_o = wr_i && wdata_i[CSR_START] && !start_q;
  assign flag_o  = flag_q;
  assign ie_o    = ie_q;
  assign start_o = start_q;
  assign scan_o  = scan_q;
  assign ch_o    = ch_q;
  assign csr_o   = {flag_q, ie_q, start_q, scan_q, 4'(ch_q)};

  AST_FLAG_RISE_NEEDS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(end_set_i)); // R3
  AST_FLAG_FALL_NEEDS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past((wr_i && !wdata_i[CSR_FLAG] && armed_q) || xfer_clr_i || lp_i)); // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_set_i && !lp_i |=> flag_q); // R9
  AST_LP_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_i |=> csr_o == 8'h00); // R1
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
  parameter int CH_W  = 4,
  parameter int GRP_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lp_i,
  input  logic            start_i,
  input  logic            scan_i,
  input  logic [CH_W-1:0] sel_i,
  input  logic            load_i,
  input  logic            ld_scan_i,
  input  logic [CH_W-1:0] ld_sel_i,
  input  logic            done_i,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_ch_o,
  output logic            res_we_o,
  output logic [CH_W-1:0] res_ch_o,
  output logic            end_set_o,
  output logic            single_done_o
);
  import adc_seq_pkg::*;

  seq_state_e      state_q;
  logic [CH_W-1:0] cur_q;
  logic [CH_W-1:0] grp_base;
  logic            last_ch;
  logic            done_ok;

  assign grp_base = {sel_i[CH_W-1:GRP_W], {GRP_W{1'b0}}};
  assign last_ch  = !scan_i || (cur_q[GRP_W-1:0] >= sel_i[GRP_W-1:0]);
  assign done_ok  = (state_q == SEQ_BUSY) && done_i && start_i && !lp_i;

  assign conv_start_o  = (state_q == SEQ_IDLE) && start_i && !lp_i;
  assign conv_ch_o     = cur_q;
  assign res_we_o      = done_ok;
  assign res_ch_o      = cur_q;
  assign end_set_o     = done_ok && last_ch;
  assign single_done_o = done_ok && !scan_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
    end else if (lp_i) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
    end else if (load_i) begin
      state_q <= SEQ_IDLE;
      cur_q   <= ld_scan_i ? {ld_sel_i[CH_W-1:GRP_W], {GRP_W{1'b0}}} : ld_sel_i;
    end else begin
      case (state_q)
        SEQ_IDLE: if (conv_start_o) state_q <= SEQ_BUSY;
        SEQ_BUSY: begin
          if (!start_i) begin
            state_q <= SEQ_IDLE;
          end else if (done_i) begin
            state_q <= SEQ_IDLE;
            if (scan_i) cur_q <= last_ch ? grp_base : cur_q + CH_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_CH_STABLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_BUSY) && $past(state_q == SEQ_BUSY) |-> $stable(cur_q)); // R7
  AST_SCAN_IN_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o && scan_i |-> cur_q[CH_W-1:GRP_W] == sel_i[CH_W-1:GRP_W]); // R6
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o && !load_i |=> !conv_start_o); // R5
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [RES_W-1:0] d_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic [RES_W-1:0] q_o
);
  logic [RES_W-1:0] res_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            res_q[g] <= '0;
      else if (we_i && wr_ch_i == CH_W'(g))   res_q[g] <= d_i;
    end
  end

  assign q_o = res_q[rd_ch_i];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 10,
  parameter int DATA_W = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lp_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              xfer_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i
);
  import adc_seq_pkg::*;

  logic            csr_sel, res_sel, csr_wr, csr_rd, xfer_clr;
  logic [7:0]      csr;
  logic            start_load, flag, ie, start, scan;
  logic [CH_W-1:0] sel_ch, res_ch;
  logic            res_we, end_set, single_done;
  logic [RES_W-1:0] res_rd;

  assign csr_sel  = reg_addr_i == '0;
  assign res_sel  = reg_addr_i[ADDR_W-1];
  assign csr_wr   = reg_wr_i && csr_sel;
  assign csr_rd   = reg_rd_i && csr_sel && !xfer_i;
  assign xfer_clr = reg_rd_i && xfer_i && res_sel;

  adc_csr #(.CH_W(CH_W)) u_csr (
    .clk_i, .rst_ni, .lp_i,
    .wr_i(csr_wr), .rd_i(csr_rd), .wdata_i(reg_wdata_i),
    .xfer_clr_i(xfer_clr), .end_set_i(end_set), .single_done_i(single_done),
    .csr_o(csr), .start_load_o(start_load), .flag_o(flag), .ie_o(ie),
    .start_o(start), .scan_o(scan), .ch_o(sel_ch)
  );

  adc_seq_fsm #(.CH_W(CH_W), .GRP_W(2)) u_fsm (
    .clk_i, .rst_ni, .lp_i,
    .start_i(start), .scan_i(scan), .sel_i(sel_ch),
    .load_i(start_load), .ld_scan_i(reg_wdata_i[CSR_SCAN]), .ld_sel_i(reg_wdata_i[CH_W-1:0]),
    .done_i(conv_done_i),
    .conv_start_o, .conv_ch_o,
    .res_we_o(res_we), .res_ch_o(res_ch), .end_set_o(end_set), .single_done_o(single_done)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i(res_we), .wr_ch_i(res_ch), .d_i(conv_result_i),
    .rd_ch_i(reg_addr_i[CH_W-1:0]), .q_o(res_rd)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (csr_sel)      reg_rdata_o[7:0]       = csr;
    else if (res_sel) reg_rdata_o[RES_W-1:0] = res_rd;
  end

  assign irq_o = flag && ie;

  AST_SINGLE_START_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_done && !csr_wr |=> !start); // R5
  AST_XFER_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_clr && !end_set |=> !flag); // R4
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> csr[CSR_IE]); // R8
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp = 1'b0, wr = 1'b0, rd = 1'b0, xfer = 1'b0, done = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [9:0]  result = '0;
  logic [15:0] rdata;
  logic        irq, cstart;
  logic [3:0]  cch;

  int checks = 0, errors = 0;
  logic [9:0] exp_res [16];

  always #5 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lp_i(lp),
    .reg_wr_i(wr), .reg_rd_i(rd), .xfer_i(xfer), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .conv_start_o(cstart), .conv_ch_o(cch),
    .conv_done_i(done), .conv_result_i(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic peek_csr(input string tag, input int exp);
    chk(rdata == 16'(exp), tag, rdata, exp);
  endtask

  task automatic csr_write(input logic [7:0] v);
    @(negedge clk); wr = 1'b1; addr = 5'd0; wdata = v;
    @(negedge clk); wr = 1'b0; #1;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic x, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; xfer = x; addr = a; #1; d = rdata;
    @(negedge clk); rd = 1'b0; xfer = 1'b0; addr = 5'd0; #1;
  endtask

  task automatic conv(input int ch, input logic [9:0] r, input bit xf, input string tag);
    for (int i = 0; i < 50 && !cstart; i++) begin @(negedge clk); #1; end
    chk(cstart == 1'b1, {tag, " strobe"}, cstart, 1);
    chk(cch == 4'(ch), {tag, " channel"}, cch, ch);
    @(negedge clk); #1;
    chk(cstart == 1'b0, {tag, " strobe width"}, cstart, 0);
    @(negedge clk);
    done = 1'b1; result = r;
    if (xf) begin rd = 1'b1; xfer = 1'b1; addr = 5'(16 + ch); end
    @(negedge clk);
    done = 1'b0; rd = 1'b0; xfer = 1'b0; addr = 5'd0; #1;
    exp_res[ch] = r;
  endtask

  initial begin
    logic [15:0] d;
    for (int i = 0; i < 16; i++) exp_res[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;

    // R1 reset state
    peek_csr("R1 reset csr", 0);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);
    chk(cstart == 1'b0, "R1 reset strobe", cstart, 0);

    // R5 R7 R8 R2 single mode sweep
    for (int c = 0; c < 16; c++) begin
      logic [9:0] v;
      v = 10'((c * 37 + 11) & 10'h3ff);
      csr_write(8'h60 | 8'(c));
      conv(c, v, 1'b0, "R5 single");
      peek_csr("R5 flag set start clear", 8'hC0 | c);
      chk(irq == 1'b1, "R8 irq on", irq, 1);
      bus_read(5'd0, 1'b0, d);
      bus_read(5'(16 + c), 1'b0, d);
      chk(d == 16'(v), "R7 result stored", d, v);
      peek_csr("R4 cpu result read keeps flag", 8'hC0 | c);
      csr_write(8'h40 | 8'(c));
      peek_csr("R3 armed clear", 8'h40 | c);
      chk(irq == 1'b0, "R8 irq off", irq, 0);
    end

    // R3 clear rules, R8 masking
    csr_write(8'h22);
    conv(2, 10'h155, 1'b0, "R3 setup");
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    csr_write(8'h02);
    peek_csr("R3 unarmed write 0 ignored", 8'h82);
    bus_read(5'd0, 1'b0, d);
    csr_write(8'h82);
    peek_csr("R3 write 1 no effect", 8'h82);
    csr_write(8'h02);
    peek_csr("R3 write 1 cancels arm", 8'h82);
    bus_read(5'd0, 1'b0, d);
    csr_write(8'h02);
    peek_csr("R3 read then write 0", 8'h02);
    csr_write(8'h80);
    peek_csr("R3 write 1 does not set", 8'h00);

    // R4 transfer read clears
    csr_write(8'h67);
    conv(7, 10'h2a5, 1'b0, "R4 setup");
    bus_read(5'd23, 1'b1, d);
    chk(d == 16'h2a5, "R4 transfer data", d, 16'h2a5);
    peek_csr("R4 transfer clears flag", 8'h47);
    chk(irq == 1'b0, "R4 irq drops", irq, 0);

    // R9 set wins over simultaneous clear
    csr_write(8'h29);
    conv(9, 10'h0f0, 1'b1, "R9 setup");
    peek_csr("R9 set wins", 8'h89);
    bus_read(5'd25, 1'b1, d);
    peek_csr("R9 cleanup", 8'h09);

    // R6 scan sweep, R10 stop
    for (int s = 0; s < 16; s++) begin
      int base;
      base = s & 12;
      csr_write(8'h30 | 8'(s));
      for (int p = 0; p < 2; p++) begin
        for (int c = base; c <= s; c++) begin
          conv(c, 10'((c * 37 + p * 5 + s) & 10'h3ff), 1'b0, "R6 scan");
          if (p == 0 && c != s) peek_csr("R6 no flag mid pass", 8'h30 | s);
          if (c == s) peek_csr("R6 flag at pass end, start kept", 8'hB0 | s);
        end
      end
      csr_write(8'h10 | 8'(s));
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); #1;
        chk(cstart == 1'b0, "R10 no strobe after stop", cstart, 0);
      end
      for (int c = base; c <= s; c++) begin
        bus_read(5'(16 + c), 1'b0, d);
        chk(d == 16'(exp_res[c]), "R7 scan result", d, exp_res[c]);
      end
      bus_read(5'd0, 1'b0, d);
      csr_write(8'h00);
      peek_csr("R3 scan cleanup", 8'h00);
    end

    // R1 low-power entry
    csr_write(8'h63);
    conv(3, 10'h3c3, 1'b0, "R1 setup");
    @(negedge clk); lp = 1'b1;
    @(negedge clk); lp = 1'b0; #1;
    peek_csr("R1 lp clears csr", 0);
    chk(irq == 1'b0, "R1 lp irq", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule